// File: doc/BRIEF.md
# Block-Lockable Page Write Controller

This block guards writes into an 8192 x 8 byte-wide storage array, held on chip as an inferable RAM. The array is divided into eight 1K-byte blocks. The block accepts already-latched 13-bit addresses, write data and separate read and write strobes. A write reaches the array only when two layers of protection both allow it. The first layer is a three-byte command prefix that has to come before every write. The second layer is an eight-bit lock register with one bit per block. A locked block refuses writes even when the prefix is correct.

After a valid prefix, the block collects up to 32 bytes of one page in a buffer. It then runs a timed internal write cycle and copies the collected bytes into the array. A separate six-byte command sets or clears any combination of block lock bits. While the internal cycle runs, reads return a status word. Bit 6 of that word flips on every read, so software can poll until the bit holds still and then knows the write has finished.

Top module: `blk_lock_wrctl`

## Requirements
- R1: Synchronous active-high reset `rst` clears all eight lock bits and leaves no write cycle running. Two successive reads of one address after reset return the same byte.
- R2: A write that is not preceded by the protection prefix leaves the array unchanged.
- R3: The protection prefix is three writes: 0xAA to 0x1555, then 0x55 to 0x0AAA, then 0xA0 to 0x1555. The writes that follow it load page bytes, and those bytes reach the array once the internal cycle ends.
- R4: A write that does not match the next expected byte or address of a command sequence returns the decoder to idle. That write, and any plain write after it, leave the array and the locks unchanged.
- R5: A page is the 32 bytes that share address bits 12:5. All 32 bytes of one page, loaded after a single prefix, are committed together in one internal cycle.
- R6: A load to a different page ends loading and starts the internal cycle. The bytes already loaded are committed. The out-of-page byte is dropped.
- R7: If no further load arrives within `WIN_CYC` cycles of the last one, the internal cycle starts on its own.
- R8: During the internal cycle a read returns a word whose bit 6 changes value on each successive read. Once the cycle ends, reads return array data and stop toggling.
- R9: Writes issued during the internal cycle are ignored, including a complete prefix followed by a load.
- R10: The lock command is 0xAA to 0x1555, 0x55 to 0x0AAA, 0x80 to 0x1555, 0xAA to 0x1555, 0x55 to 0x0AAA, then a mask byte written to 0x1555. Mask bit i sets the lock of block i (address bits 12:10 equal to i). A prefixed page write into a locked block leaves it unchanged, while unlocked blocks still accept writes.
- R11: The same six writes with the mask byte sent to 0x0AAA clear the locks selected by the mask and leave every other lock bit as it was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 13 | Latched byte address for reads and writes |
| wdata | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe; data appears on rdata one cycle later |
| rdata | output | 8 | Array data, or the toggle status word while a write cycle runs |

## Verification
The main write path is tried with plain unprefixed writes, a full 32-byte page, a short burst ended by a load to another page, and a short burst ended by the load window running out. Together these separate the commit paths and confirm that only bytes from the buffered page land. Lock and unlock commands with overlapping masks are run against writes into locked and unlocked blocks; this shows both that the lock overrides a valid prefix and that unlock touches only the masked bits. Sequences are also broken partway through and sent during the busy period, and a random mix of pages, offsets, burst lengths and lock masks then runs against a bench model of the array and the lock bits.

// File: rtl/blkwr_pkg.sv
package blkwr_pkg;
  // command addresses and key bytes
  localparam logic [12:0] CMD_ADDR_HI = 13'h1555;
  localparam logic [12:0] CMD_ADDR_LO = 13'h0AAA;
  localparam logic [7:0]  KEY_FIRST   = 8'hAA;
  localparam logic [7:0]  KEY_SECOND  = 8'h55;
  localparam logic [7:0]  KEY_WRITE   = 8'hA0;
  localparam logic [7:0]  KEY_LOCK    = 8'h80;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_P1, SQ_P2, SQ_ARM, SQ_L1, SQ_L2, SQ_L3
  } seq_t;
endpackage

// File: rtl/blkwr_mem.sv
module blkwr_mem #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ram [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) ram[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    q <= ram[raddr];
  end
endmodule

// File: rtl/blkwr_seq.sv
module blkwr_seq import blkwr_pkg::*; #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int NBLK   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              load_req,
  output logic              lock_we,
  output logic              lock_set,
  output logic [NBLK-1:0]   lock_mask
);
  seq_t st, nxt;
  logic at_hi, at_lo;

  assign at_hi     = (addr == ADDR_W'(CMD_ADDR_HI));
  assign at_lo     = (addr == ADDR_W'(CMD_ADDR_LO));
  assign lock_mask = wdata[NBLK-1:0];

  always_comb begin
    nxt      = st;
    load_req = 1'b0;
    lock_we  = 1'b0;
    lock_set = 1'b0;
    if (busy) begin
      nxt = SQ_IDLE;
    end else if (wr_en) begin
      case (st)
        SQ_IDLE: nxt = (at_hi && wdata == DATA_W'(KEY_FIRST))  ? SQ_P1 : SQ_IDLE;
        SQ_P1:   nxt = (at_lo && wdata == DATA_W'(KEY_SECOND)) ? SQ_P2 : SQ_IDLE;
        SQ_P2: begin
          if (at_hi && wdata == DATA_W'(KEY_WRITE))     nxt = SQ_ARM;
          else if (at_hi && wdata == DATA_W'(KEY_LOCK)) nxt = SQ_L1;
          else                                          nxt = SQ_IDLE;
        end
        SQ_ARM:  load_req = 1'b1;
        SQ_L1:   nxt = (at_hi && wdata == DATA_W'(KEY_FIRST))  ? SQ_L2 : SQ_IDLE;
        SQ_L2:   nxt = (at_lo && wdata == DATA_W'(KEY_SECOND)) ? SQ_L3 : SQ_IDLE;
        SQ_L3: begin
          nxt      = SQ_IDLE;
          lock_we  = at_hi | at_lo;
          lock_set = at_hi;
        end
        default: nxt = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= SQ_IDLE;
    else     st <= nxt;
  end
endmodule

// File: rtl/blkwr_page.sv
module blkwr_page #(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int PAGE_W    = 5,
  parameter int NBLK      = 8,
  parameter int WIN_CYC   = 16,
  parameter int WRITE_CYC = 48   // must exceed the page size
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NBLK-1:0]   lock_q,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PG_W       = ADDR_W - PAGE_W;
  localparam int BLK_W      = $clog2(NBLK);
  localparam int WC_W       = $clog2(WRITE_CYC);
  localparam int WN_W       = $clog2(WIN_CYC) + 1;

  logic [DATA_W-1:0]     pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld;
  logic [PG_W-1:0]       page_q;
  logic                  loading;
  logic [WN_W-1:0]       wcnt;
  logic [WC_W-1:0]       bcnt;
  logic [PAGE_W:0]       cidx;
  logic [PAGE_W-1:0]     off;
  logic                  same_pg, start;

  assign off     = addr[PAGE_W-1:0];
  assign same_pg = (addr[ADDR_W-1:PAGE_W] == page_q);
  assign start   = loading && ((load_req && !same_pg) || (!load_req && wcnt == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      loading <= 1'b0;
      busy    <= 1'b0;
      vld     <= '0;
      page_q  <= '0;
      wcnt    <= '0;
      bcnt    <= '0;
      cidx    <= '0;
    end else begin
      if (start) begin
        loading <= 1'b0;
        busy    <= 1'b1;
        bcnt    <= WC_W'(WRITE_CYC - 1);
        cidx    <= '0;
      end else if (load_req && !busy) begin
        if (!loading) begin
          page_q  <= addr[ADDR_W-1:PAGE_W];
          vld     <= PAGE_BYTES'(1) << off;
          loading <= 1'b1;
        end else begin
          vld[off] <= 1'b1;
        end
        wcnt <= WN_W'(WIN_CYC - 1);
      end else if (loading) begin
        wcnt <= wcnt - 1'b1;
      end
      if (busy) begin
        if (bcnt == '0) begin
          busy <= 1'b0;
          vld  <= '0;
        end else begin
          bcnt <= bcnt - 1'b1;
        end
        if (!cidx[PAGE_W]) cidx <= cidx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (load_req && !busy && !start) pbuf[off] <= wdata;
  end

  // one buffered byte per cycle into the array, skipped for a locked block
  assign mem_we    = busy && !cidx[PAGE_W] && vld[cidx[PAGE_W-1:0]]
                     && !lock_q[page_q[PG_W-1 -: BLK_W]];
  assign mem_waddr = {page_q, cidx[PAGE_W-1:0]};
  assign mem_wdata = pbuf[cidx[PAGE_W-1:0]];
endmodule

// File: rtl/blk_lock_wrctl.sv
module blk_lock_wrctl #(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int PAGE_W    = 5,
  parameter int NBLK      = 8,
  parameter int WIN_CYC   = 16,
  parameter int WRITE_CYC = 48,
  parameter int TOG_BIT   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata
);
  logic              busy, load_req, lock_we, lock_set;
  logic [NBLK-1:0]   lock_mask, lock_q;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata, mem_q, stat_q;
  logic              tog, sel_q;

  blkwr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBLK(NBLK)) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .busy(busy), .addr(addr), .wdata(wdata),
    .load_req(load_req), .lock_we(lock_we), .lock_set(lock_set), .lock_mask(lock_mask)
  );

  blkwr_page #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .NBLK(NBLK),
               .WIN_CYC(WIN_CYC), .WRITE_CYC(WRITE_CYC)) u_page (
    .clk(clk), .rst(rst), .load_req(load_req), .addr(addr), .wdata(wdata),
    .lock_q(lock_q), .busy(busy), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata)
  );

  blkwr_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(addr), .q(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= '0;
    end else if (lock_we) begin
      lock_q <= lock_set ? (lock_q | lock_mask) : (lock_q & ~lock_mask);
    end
  end

  // status word for reads during the internal write cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      tog    <= 1'b0;
      sel_q  <= 1'b0;
      stat_q <= '0;
    end else begin
      sel_q <= busy;
      if (rd_en && busy) begin
        stat_q          <= '0;
        stat_q[TOG_BIT] <= tog;
        tog             <= ~tog;
      end
    end
  end

  assign rdata = sel_q ? stat_q : mem_q;
endmodule

// File: rtl/blkwr_chk.sv
module blkwr_chk #(
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 8,
  parameter int NBLK    = 8,
  parameter int TOG_BIT = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [DATA_W-1:0] rdata,
  input logic              busy,
  input logic [NBLK-1:0]   lock_q,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_waddr
);
  localparam int BLK_W = $clog2(NBLK);

  // R1
  locks_clear_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> lock_q == '0);

  // R9
  array_write_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R10
  no_write_to_locked_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !lock_q[mem_waddr[ADDR_W-1 -: BLK_W]]);

  // R11
  locks_steady_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(lock_q) |-> !$past(busy));

  // R8
  status_toggles_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && busy) ##1 (rd_en && busy) |=> rdata[TOG_BIT] != $past(rdata[TOG_BIT]));
endmodule

bind blk_lock_wrctl blkwr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBLK(NBLK),
                                .TOG_BIT(TOG_BIT)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rdata(rdata), .busy(busy),
  .lock_q(lock_q), .mem_we(mem_we), .mem_waddr(mem_waddr)
);

// File: tb/test_blk_lock_wrctl.sv
`timescale 1ns/1ps
module test_blk_lock_wrctl;
  localparam int WIN = 16;
  localparam int WC  = 48;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  rdata;

  int vectors = 0;
  int miscomp = 0;
  bit finished = 1'b0;

  logic [7:0] model [8192];
  logic [7:0] lk = '0;

  always #5 clk = ~clk;

  blk_lock_wrctl #(.WIN_CYC(WIN), .WRITE_CYC(WC)) i_blk_lock_wrctl (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscomp++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic prefix();
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'hA0);
  endtask

  task automatic lock_cmd(input logic [7:0] m, input bit set);
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'h80);
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55);
    wr(set ? 13'h1555 : 13'h0AAA, m);
    lk = set ? (lk | m) : (lk & ~m);
  endtask

  // wait past the load window, then poll until two reads agree
  task automatic poll(output int togs);
    logic [7:0] p, c;
    togs = 0;
    idle(WIN + 2);
    rd(13'h0, p);
    for (int i = 0; i < 300; i++) begin
      rd(13'h0, c);
      if (c == p) break;
      if (c[6] != p[6]) togs++;
      p = c;
    end
  endtask

  function automatic logic blk_open(input logic [12:0] a);
    return !lk[a[12:10]];
  endfunction

  task automatic page_wr(input logic [12:0] base, input int off, input int n, output int togs);
    logic [12:0] a;
    logic [7:0]  d;
    prefix();
    for (int i = 0; i < n; i++) begin
      a = {base[12:5], 5'((off + i) % 32)};
      d = 8'($urandom);
      wr(a, d);
      if (blk_open(a)) model[a] = d;
    end
    poll(togs);
  endtask

  task automatic chk_page(input logic [12:0] base, input string tag);
    logic [7:0] d;
    for (int i = 0; i < 32; i++) begin
      rd({base[12:5], 5'(i)}, d);
      check(tag, d, model[{base[12:5], 5'(i)}]);
    end
  endtask

  task automatic chk_one(input logic [12:0] a, input string tag);
    logic [7:0] d;
    rd(a, d);
    check(tag, d, model[a]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscomp++;
      vectors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
    end
  end

  initial begin
    int t;
    logic [7:0] a0, a1;
    logic [12:0] pa;
    void'($urandom(32'd4711));
    for (int i = 0; i < 8192; i++) model[i] = '0;
    idle(3);
    rst = 1'b0;
    idle(2);

    // R1: idle after reset, reads stable
    rd(13'h0123, a0); rd(13'h0123, a1);
    check("R1 stable read", a1, a0);
    check("R1 reset data", a1, model[13'h0123]);

    // R2: plain write ignored
    wr(13'h0100, 8'h5A);
    idle(WIN + WC + 5);
    chk_one(13'h0100, "R2 unprotected write");

    // R3 / R5 / R8: full page
    page_wr(13'h0200, 0, 32, t);
    check("R8 toggles seen", 8'(t >= 2), 8'd1);
    rd(13'h0, a0); rd(13'h0, a1);
    check("R8 toggling stopped", a1, a0);
    chk_page(13'h0200, "R3 R5 full page");

    // R4: broken prefix
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'h77);
    wr(13'h0300, 8'h33);
    idle(WIN + WC + 5);
    chk_one(13'h0300, "R4 aborted sequence");
    chk_one(13'h1555, "R4 aborting byte");

    // R6: out-of-page load ends loading
    prefix();
    wr(13'h0400, 8'h11); wr(13'h0401, 8'h22); wr(13'h0402, 8'h33);
    model[13'h0400] = 8'h11; model[13'h0401] = 8'h22; model[13'h0402] = 8'h33;
    wr(13'h0460, 8'h99);
    poll(t);
    chk_one(13'h0400, "R6 committed byte");
    chk_one(13'h0402, "R6 committed byte");
    chk_one(13'h0460, "R6 dropped byte");

    // R7: window expiry starts the cycle
    prefix();
    wr(13'h0500, 8'hC1); wr(13'h0501, 8'hC2);
    model[13'h0500] = 8'hC1; model[13'h0501] = 8'hC2;
    idle(WIN + 2);
    rd(13'h0, a0); rd(13'h0, a1);
    check("R7 busy after window", 8'(a0[6] != a1[6]), 8'd1);
    poll(t);
    chk_one(13'h0500, "R7 committed");
    chk_one(13'h0501, "R7 committed");

    // R9: writes during busy ignored
    prefix();
    wr(13'h0600, 8'h5C);
    model[13'h0600] = 8'h5C;
    idle(WIN + 2);
    prefix();
    wr(13'h0700, 8'h77);
    poll(t);
    chk_one(13'h0700, "R9 write during busy");
    chk_one(13'h0600, "R9 prior page");

    // R10: lock blocks 0 and 2
    lock_cmd(8'h05, 1'b1);
    page_wr(13'h0800, 0, 4, t);
    chk_page(13'h0800, "R10 locked block");
    page_wr(13'h0440, 3, 6, t);
    chk_page(13'h0440, "R10 open block");

    // R11: unlock block 2 only
    lock_cmd(8'h04, 1'b0);
    page_wr(13'h0840, 0, 5, t);
    chk_page(13'h0840, "R11 unlocked block");
    page_wr(13'h0040, 0, 5, t);
    chk_page(13'h0040, "R11 still locked");

    // random mix
    for (int it = 0; it < 30; it++) begin
      case ($urandom % 4)
        0: lock_cmd(8'($urandom), 1'($urandom));
        1: begin
          pa = 13'($urandom);
          wr(pa, 8'($urandom));
          idle(WIN + 2);
          chk_one(pa, "R2 random plain write");
        end
        default: begin
          pa = 13'($urandom);
          page_wr(pa, int'($urandom % 32), 1 + int'($urandom % 32), t);
          chk_page(pa, "R3 R10 random page");
        end
      endcase
    end

    // R1: reset clears locks
    lock_cmd(8'h01, 1'b1);
    @(negedge clk); rst = 1'b1;
    idle(2); rst = 1'b0; lk = '0;
    idle(1);
    page_wr(13'h0080, 0, 8, t);
    chk_page(13'h0080, "R1 locks cleared");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end
endmodule